// File: doc/BRIEF.md
# Multicycle RISC Datapath

This block is the datapath of a 32-bit load/store processor that spends several clock cycles on each instruction. One memory port serves both instruction fetch and data access, and one ALU does every addition, subtraction, comparison and address calculation. Holding registers carry values from one step to the next: an instruction register, a memory data register, two operand registers, and a register that keeps the last ALU result.

Every steering and write-enable signal comes in as an input from a separate sequencer, so the block has no notion of instruction phases. The datapath returns the opcode field of the held instruction and the live ALU zero flag so that the sequencer can choose its next step. The memory itself sits outside the block. The block drives a byte address, store data and read/write strobes, and takes back a read word in the same cycle.

Top module: `mc_datapath`

## Requirements
- R1: While `rst_n` is low and after it is released, the PC, the instruction register, the memory data register, both operand registers, the ALU result register and all 32 general registers hold zero. With all controls low after reset, `mem_addr`, `mem_wdata` and `opcode` read zero.
- R2: `mem_addr` equals the PC when `addr_sel` is 0, and the held ALU result when `addr_sel` is 1.
- R3: The instruction register captures `mem_rdata` at a rising edge only when `ir_we` is 1, and otherwise keeps its value. `opcode` presents bits 31:26 of the instruction register.
- R4: The first ALU operand is the PC when `opa_sel` is 0, and the first operand register when `opa_sel` is 1.
- R5: `opb_sel` picks the second ALU operand. 00 selects the second operand register, 01 selects the constant 4, 10 selects instruction bits 15:0 sign-extended, and 11 selects that sign-extended value shifted left by two.
- R6: `alu_mode` 00 adds and 01 subtracts (first minus second). With 10, instruction bits 5:0 choose the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than giving 1 or 0. Any other code, and mode 11, adds. `zero` is 1 exactly when the current ALU result is zero.
- R7: `npc_sel` picks the value loaded into the PC. 00 selects the live ALU result, 01 selects the held ALU result, and 10 selects the jump target formed from PC bits 31:28, instruction bits 25:0 and two zero bits. 11 leaves the PC unchanged.
- R8: The PC loads at a rising edge when `pc_we` is 1, or when `pc_we_cond` is 1 and `zero` is 1. Otherwise it holds.
- R9: When `rf_we` is 1, a general register is written at the rising edge. Its number is instruction bits 20:16 when `dst_sel` is 0 and bits 15:11 when `dst_sel` is 1. Its data is the held ALU result when `wb_sel` is 0 and the memory data register when `wb_sel` is 1.
- R10: General register 0 always reads as zero, and writes to it are discarded.
- R11: The memory data register, both operand registers and the ALU result register load on every rising edge. The operand registers take the general registers numbered by instruction bits 25:21 and 20:16, so each value appears one cycle after its source.
- R12: `mem_wdata` is the second operand register. `mem_rd` and `mem_wr` follow `mem_rd_en` and `mem_wr_en` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_we | input | 1 | Unconditional PC load |
| pc_we_cond | input | 1 | PC load qualified by the zero flag |
| addr_sel | input | 1 | Memory address source: 0 PC, 1 held ALU result |
| mem_rd_en | input | 1 | Memory read request |
| mem_wr_en | input | 1 | Memory write request |
| wb_sel | input | 1 | Register write data: 0 held ALU result, 1 memory data register |
| ir_we | input | 1 | Instruction register load |
| dst_sel | input | 1 | Destination field: 0 bits 20:16, 1 bits 15:11 |
| rf_we | input | 1 | General register write |
| opa_sel | input | 1 | First ALU operand: 0 PC, 1 operand register A |
| opb_sel | input | 2 | Second ALU operand select |
| alu_mode | input | 2 | ALU operation mode |
| npc_sel | input | 2 | Next PC source |
| mem_addr | output | 32 | Byte address to memory |
| mem_wdata | output | 32 | Store data to memory |
| mem_rd | output | 1 | Read strobe to memory |
| mem_wr | output | 1 | Write strobe to memory |
| mem_rdata | input | 32 | Word returned by memory |
| opcode | output | 6 | Bits 31:26 of the instruction register |
| zero | output | 1 | ALU result is zero |

## Verification
Two functions of this block can act on the same rising edge, and each pairing needs a defined ordering. In the first, a conditional PC load uses the live zero flag in the same edge that captures the same ALU result into the held-result register. In the second, a store to an address lands in the same edge in which the memory data register samples that address, and the register must take the old word. A phase of unconstrained control words drives every combination of enables and selects on each cycle, so a store and a read of one address coincide, and PC loads coincide with result capture. A behavioural model in the bench checks the address, store data, strobes, opcode and zero flag on every clock, and checks the memory contents after a directed program.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

  localparam int WORD_W  = 32;
  localparam int FUNCT_W = 6;
  localparam int IMM_W   = 16;
  localparam int JIDX_W  = 26;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    OPB_REG    = 2'b00,
    OPB_FOUR   = 2'b01,
    OPB_IMM    = 2'b10,
    OPB_IMM_X4 = 2'b11
  } opb_sel_e;

  typedef enum logic [1:0] {
    NPC_LIVE = 2'b00,
    NPC_HELD = 2'b01,
    NPC_JUMP = 2'b10,
    NPC_KEEP = 2'b11
  } npc_sel_e;

  typedef enum logic [1:0] {
    MODE_ADD   = 2'b00,
    MODE_SUB   = 2'b01,
    MODE_FUNCT = 2'b10,
    MODE_SPARE = 2'b11
  } alu_mode_e;

  typedef enum logic [2:0] {
    AOP_ADD,
    AOP_SUB,
    AOP_AND,
    AOP_OR,
    AOP_SLT
  } alu_op_e;

  localparam logic [FUNCT_W-1:0] FN_ADD = 6'h20;
  localparam logic [FUNCT_W-1:0] FN_SUB = 6'h22;
  localparam logic [FUNCT_W-1:0] FN_AND = 6'h24;
  localparam logic [FUNCT_W-1:0] FN_OR  = 6'h25;
  localparam logic [FUNCT_W-1:0] FN_SLT = 6'h2A;

  // Map the mode and function field onto one ALU operation.
  function automatic alu_op_e pick_op(alu_mode_e mode, logic [FUNCT_W-1:0] fn);
    alu_op_e op;
    op = AOP_ADD;
    case (mode)
      MODE_SUB:   op = AOP_SUB;
      MODE_FUNCT: begin
        case (fn)
          FN_SUB:  op = AOP_SUB;
          FN_AND:  op = AOP_AND;
          FN_OR:   op = AOP_OR;
          FN_SLT:  op = AOP_SLT;
          default: op = AOP_ADD;
        endcase
      end
      default:    op = AOP_ADD;
    endcase
    return op;
  endfunction

  function automatic word_t alu_eval(alu_op_e op, word_t a, word_t b);
    word_t r;
    case (op)
      AOP_SUB: r = a - b;
      AOP_AND: r = a & b;
      AOP_OR:  r = a | b;
      AOP_SLT: r = ($signed(a) < $signed(b)) ? word_t'(1) : '0;
      default: r = a + b;
    endcase
    return r;
  endfunction

  function automatic word_t sext_imm(logic [IMM_W-1:0] v);
    return {{(WORD_W-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  function automatic word_t jump_target(word_t pc, logic [JIDX_W-1:0] idx);
    return {pc[WORD_W-1:WORD_W-4], idx, 2'b00};
  endfunction

endpackage

// File: rtl/mcd_regfile.sv
module mcd_regfile #(
  parameter int W = 32,
  parameter int N = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [$clog2(N)-1:0] rd_a_idx,
  input  logic [$clog2(N)-1:0] rd_b_idx,
  input  logic                 wr_en,
  input  logic [$clog2(N)-1:0] wr_idx,
  input  logic [W-1:0]         wr_data,
  output logic [W-1:0]         rd_a,
  output logic [W-1:0]         rd_b
);
  localparam int IW = $clog2(N);

  logic [W-1:0] regs [N];

  // Entry 0 is never written: it keeps its reset value of zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else begin
      for (int i = 1; i < N; i++) begin
        if (wr_en && (wr_idx == IW'(i))) regs[i] <= wr_data;
      end
    end
  end

  assign rd_a = (rd_a_idx == '0) ? '0 : regs[rd_a_idx];
  assign rd_b = (rd_b_idx == '0) ? '0 : regs[rd_b_idx];

endmodule

// File: rtl/mcd_alu.sv
module mcd_alu
  import mcd_pkg::*;
(
  input  word_t              op_a,
  input  word_t              op_b,
  input  logic [1:0]         mode,
  input  logic [FUNCT_W-1:0] funct,
  output word_t              result,
  output logic               is_zero
);
  alu_op_e op;

  assign op      = pick_op(alu_mode_e'(mode), funct);
  assign result  = alu_eval(op, op_a, op_b);
  assign is_zero = (result == '0);

endmodule

// File: rtl/mcd_pc_unit.sv
module mcd_pc_unit
  import mcd_pkg::*;
#(
  parameter word_t RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_uncond,
  input  logic              wr_cond,
  input  logic              alu_zero,
  input  logic [1:0]        npc_sel,
  input  word_t             live_res,
  input  word_t             held_res,
  input  logic [JIDX_W-1:0] jidx,
  output word_t             pc_q,
  output logic              pc_load
);
  word_t pc_next;

  assign pc_load = wr_uncond | (wr_cond & alu_zero);

  always_comb begin
    case (npc_sel_e'(npc_sel))
      NPC_LIVE: pc_next = live_res;
      NPC_HELD: pc_next = held_res;
      NPC_JUMP: pc_next = jump_target(pc_q, jidx);
      default:  pc_next = pc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pc_q <= RESET_PC;
    else if (pc_load) pc_q <= pc_next;
  end

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mcd_pkg::*;
#(
  parameter int    REG_CNT  = 32,
  parameter word_t RESET_PC = '0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pc_we,
  input  logic        pc_we_cond,
  input  logic        addr_sel,
  input  logic        mem_rd_en,
  input  logic        mem_wr_en,
  input  logic        wb_sel,
  input  logic        ir_we,
  input  logic        dst_sel,
  input  logic        rf_we,
  input  logic        opa_sel,
  input  logic [1:0]  opb_sel,
  input  logic [1:0]  alu_mode,
  input  logic [1:0]  npc_sel,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic        mem_rd,
  output logic        mem_wr,
  input  logic [31:0] mem_rdata,
  output logic [5:0]  opcode,
  output logic        zero
);
  localparam int RIDX_W = $clog2(REG_CNT);

  // Holding registers between steps
  word_t ir_q, mdr_q, a_q, b_q, hold_q;
  word_t pc_q;

  // Named internal events and values
  logic              pc_load;
  word_t             opa, opb, alu_res;
  logic              alu_zero;
  logic [RIDX_W-1:0] rs_idx, rt_idx, rd_idx, wr_idx;
  word_t             rf_a, rf_b, wr_data;

  assign rs_idx = RIDX_W'(ir_q[25:21]);
  assign rt_idx = RIDX_W'(ir_q[20:16]);
  assign rd_idx = RIDX_W'(ir_q[15:11]);
  assign wr_idx = dst_sel ? rd_idx : rt_idx;
  assign wr_data = wb_sel ? mdr_q : hold_q;

  mcd_regfile #(.W(WORD_W), .N(REG_CNT)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_a_idx (rs_idx),
    .rd_b_idx (rt_idx),
    .wr_en    (rf_we),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .rd_a     (rf_a),
    .rd_b     (rf_b)
  );

  assign opa = opa_sel ? a_q : pc_q;

  always_comb begin
    case (opb_sel_e'(opb_sel))
      OPB_REG:    opb = b_q;
      OPB_FOUR:   opb = word_t'(4);
      OPB_IMM:    opb = sext_imm(ir_q[IMM_W-1:0]);
      default:    opb = sext_imm(ir_q[IMM_W-1:0]) << 2;
    endcase
  end

  mcd_alu u_alu (
    .op_a    (opa),
    .op_b    (opb),
    .mode    (alu_mode),
    .funct   (ir_q[FUNCT_W-1:0]),
    .result  (alu_res),
    .is_zero (alu_zero)
  );

  mcd_pc_unit #(.RESET_PC(RESET_PC)) u_pc (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_uncond (pc_we),
    .wr_cond   (pc_we_cond),
    .alu_zero  (alu_zero),
    .npc_sel   (npc_sel),
    .live_res  (alu_res),
    .held_res  (hold_q),
    .jidx      (ir_q[JIDX_W-1:0]),
    .pc_q      (pc_q),
    .pc_load   (pc_load)
  );

  // The instruction register is the only holding register with an enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q   <= '0;
      mdr_q  <= '0;
      a_q    <= '0;
      b_q    <= '0;
      hold_q <= '0;
    end else begin
      if (ir_we) ir_q <= mem_rdata;
      mdr_q  <= mem_rdata;
      a_q    <= rf_a;
      b_q    <= rf_b;
      hold_q <= alu_res;
    end
  end

  assign mem_addr  = addr_sel ? hold_q : pc_q;
  assign mem_wdata = b_q;
  assign mem_rd    = mem_rd_en;
  assign mem_wr    = mem_wr_en;
  assign opcode    = ir_q[31:26];
  assign zero      = alu_zero;

endmodule

// File: rtl/mc_datapath_chk.sv
module mc_datapath_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pc_we,
  input logic        pc_we_cond,
  input logic        zero,
  input logic        ir_we,
  input logic [1:0]  npc_sel,
  input logic [31:0] mem_rdata,
  input logic [31:0] pc_q,
  input logic [31:0] ir_q,
  input logic [31:0] mdr_q,
  input logic [31:0] a_q,
  input logic [31:0] hold_q,
  input logic        pc_load
);

  // R8: no load request, PC stays put
  p_pc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pc_we || (pc_we_cond && zero)) |=> $stable(pc_q));

  // R8: taken conditional load with held-result source
  p_cond_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && !pc_we && npc_sel == 2'b01) |=> (pc_q == $past(hold_q)));

  // R7: jump keeps the upper four PC bits and is word aligned
  p_jump_form_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we && npc_sel == 2'b10) |=>
      (pc_q[1:0] == 2'b00 && pc_q[31:28] == $past(pc_q[31:28])));

  // R3: instruction register holds without its enable
  p_ir_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_we |=> $stable(ir_q));

  // R3: instruction register captures memory data with its enable
  p_ir_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ir_we |=> (ir_q == $past(mem_rdata)));

  // R11: memory data register follows the read word every cycle
  p_mdr_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (mdr_q == $past(mem_rdata)));

  // R10: a source field of zero yields a zero operand
  p_reg0_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_q[25:21] == 5'd0) |=> (a_q == 32'd0));

endmodule

bind mc_datapath mc_datapath_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pc_we      (pc_we),
  .pc_we_cond (pc_we_cond),
  .zero       (zero),
  .ir_we      (ir_we),
  .npc_sel    (npc_sel),
  .mem_rdata  (mem_rdata),
  .pc_q       (pc_q),
  .ir_q       (ir_q),
  .mdr_q      (mdr_q),
  .a_q        (a_q),
  .hold_q     (hold_q),
  .pc_load    (pc_load)
);

// File: tb/mc_datapath_tb.sv
module mc_datapath_tb;

  logic clk = 1'b0;
  always #5 clk = ~clk;
  logic rst_n = 1'b0;

  // Control word: 15 pc_we, 14 pc_we_cond, 13 addr_sel, 12 mem_rd_en,
  // 11 mem_wr_en, 10 wb_sel, 9 ir_we, 8 dst_sel, 7 rf_we, 6 opa_sel,
  // 5:4 opb_sel, 3:2 alu_mode, 1:0 npc_sel
  logic [15:0] cw = 16'h0000;
  logic pc_we, pc_we_cond, addr_sel, mem_rd_en, mem_wr_en, wb_sel, ir_we;
  logic dst_sel, rf_we, opa_sel;
  logic [1:0] opb_sel, alu_mode, npc_sel;
  assign {pc_we, pc_we_cond, addr_sel, mem_rd_en, mem_wr_en, wb_sel, ir_we,
          dst_sel, rf_we, opa_sel, opb_sel, alu_mode, npc_sel} = cw;

  localparam logic [15:0] S_FETCH  = 16'h9210;
  localparam logic [15:0] S_DECODE = 16'h0030;
  localparam logic [15:0] S_MEMADR = 16'h0060;
  localparam logic [15:0] S_RTEXE  = 16'h0048;
  localparam logic [15:0] S_BEQ    = 16'h4045;
  localparam logic [15:0] S_JMP    = 16'h8002;
  localparam logic [15:0] S_LWMEM  = 16'h3000;
  localparam logic [15:0] S_SWMEM  = 16'h2800;
  localparam logic [15:0] S_RTWB   = 16'h0180;
  localparam logic [15:0] S_LWWB   = 16'h0480;

  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_rd, mem_wr, zero;
  logic [5:0]  opcode;

  // Word-addressed memory model, 64 words
  logic [31:0] mem [64];
  assign mem_rdata = mem[mem_addr[7:2]];
  always @(posedge clk) if (rst_n && mem_wr) mem[mem_addr[7:2]] <= mem_wdata;

  mc_datapath u_dut (
    .clk(clk), .rst_n(rst_n), .pc_we(pc_we), .pc_we_cond(pc_we_cond),
    .addr_sel(addr_sel), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .wb_sel(wb_sel), .ir_we(ir_we), .dst_sel(dst_sel), .rf_we(rf_we),
    .opa_sel(opa_sel), .opb_sel(opb_sel), .alu_mode(alu_mode),
    .npc_sel(npc_sel), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdata(mem_rdata),
    .opcode(opcode), .zero(zero)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // Behavioural reference state
  logic [31:0] m_pc, m_ir, m_mdr, m_a, m_b, m_out;
  logic [31:0] m_rf [32];

  function automatic logic [31:0] ref_alu(input logic [31:0] x, input logic [31:0] y,
                                          input logic [1:0] md, input logic [5:0] fn);
    if (md == 2'd1) return x - y;
    if (md == 2'd2) begin
      if (fn == 6'h22) return x - y;
      if (fn == 6'h24) return x & y;
      if (fn == 6'h25) return x | y;
      if (fn == 6'h2A) return (signed'(x) < signed'(y)) ? 32'd1 : 32'd0;
    end
    return x + y;
  endfunction

  function automatic logic [31:0] ref_opb(input logic [1:0] s, input logic [31:0] b,
                                          input logic [31:0] ir);
    logic [31:0] ext;
    ext = {{16{ir[15]}}, ir[15:0]};
    if (s == 2'd0) return b;
    if (s == 2'd1) return 32'd4;
    if (s == 2'd2) return ext;
    return ext * 4;
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    logic [31:0] t_res, t_addr;
    logic [4:0]  t_dst;
    if (!rst_n) begin
      m_pc <= 0; m_ir <= 0; m_mdr <= 0; m_a <= 0; m_b <= 0; m_out <= 0;
      for (int i = 0; i < 32; i++) m_rf[i] <= 0;
    end else begin
      t_res  = ref_alu(cw[6] ? m_a : m_pc, ref_opb(cw[5:4], m_b, m_ir), cw[3:2], m_ir[5:0]);
      t_addr = cw[13] ? m_out : m_pc;
      if (cw[15] || (cw[14] && t_res == 0)) begin
        if (cw[1:0] == 2'd0) m_pc <= t_res;
        else if (cw[1:0] == 2'd1) m_pc <= m_out;
        else if (cw[1:0] == 2'd2) m_pc <= {m_pc[31:28], m_ir[25:0], 2'b00};
      end
      if (cw[9]) m_ir <= mem[t_addr[7:2]];
      m_mdr <= mem[t_addr[7:2]];
      m_a   <= m_rf[m_ir[25:21]];
      m_b   <= m_rf[m_ir[20:16]];
      m_out <= t_res;
      t_dst = cw[8] ? m_ir[15:11] : m_ir[20:16];
      if (cw[7] && t_dst != 0) m_rf[t_dst] <= cw[10] ? m_mdr : m_out;
    end
  end

  // Apply one control word and compare every output with the model
  task automatic step(input logic [15:0] c);
    logic [31:0] e_res;
    @(negedge clk);
    cw = c;
    #1;
    e_res = ref_alu(cw[6] ? m_a : m_pc, ref_opb(cw[5:4], m_b, m_ir), cw[3:2], m_ir[5:0]);
    chk("R2 address", mem_addr, cw[13] ? m_out : m_pc);
    chk("R12 store data", mem_wdata, m_b);
    chk("R3 opcode", {26'b0, opcode}, {26'b0, m_ir[31:26]});
    chk("R6 zero flag", {31'b0, zero}, {31'b0, (e_res == 0)});
    chk("R12 strobes", {30'b0, mem_rd, mem_wr}, {30'b0, c[12], c[11]});
  endtask

  task automatic run_lw;  step(S_FETCH); step(S_DECODE); step(S_MEMADR); step(S_LWMEM); step(S_LWWB); endtask
  task automatic run_sw;  step(S_FETCH); step(S_DECODE); step(S_MEMADR); step(S_SWMEM); endtask
  task automatic run_rt;  step(S_FETCH); step(S_DECODE); step(S_RTEXE);  step(S_RTWB); endtask
  task automatic run_beq; step(S_FETCH); step(S_DECODE); step(S_BEQ); endtask
  task automatic run_j;   step(S_FETCH); step(S_DECODE); step(S_JMP); endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h1000_0000 + i;
    mem[0]  = 32'h8C010080; // load r1 <- [0x80]
    mem[1]  = 32'h8C020084; // load r2 <- [0x84]
    mem[2]  = 32'h00221820; // r3 = r1 + r2
    mem[3]  = 32'h0041202A; // r4 = r2 < r1
    mem[4]  = 32'h00222822; // r5 = r1 - r2
    mem[5]  = 32'h00223024; // r6 = r1 & r2
    mem[6]  = 32'h00223825; // r7 = r1 | r2
    mem[7]  = 32'h00210020; // r0 = r1 + r1 (discarded)
    mem[8]  = 32'hAC000088; // store r0 -> [0x88]
    mem[9]  = 32'hAC03008C; // store r3 -> [0x8C]
    mem[10] = 32'h10210002; // equal r1,r1: to 0x34
    mem[11] = 32'hAC010090; // trap
    mem[12] = 32'hAC010090; // trap
    mem[13] = 32'h10220005; // equal r1,r2: falls through
    mem[14] = 32'h08000011; // jump to 0x44
    mem[15] = 32'hAC010090; // trap
    mem[16] = 32'hAC010090; // trap
    mem[17] = 32'hAC050094; // store r5 -> [0x94]
    mem[18] = 32'hAC040098; // store r4 -> [0x98]
    mem[19] = 32'hAC06009C; // store r6 -> [0x9C]
    mem[20] = 32'hAC0700A0; // store r7 -> [0xA0]
    mem[32] = 32'h0000_0007;
    mem[33] = 32'hFFFF_FFF0;
    mem[34] = 32'hDEAD_BEEF;
    mem[36] = 32'h1234_5678;

    cw = 16'h0000;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    step(16'h0000);
    chk("R1 reset address", mem_addr, 32'h0);
    chk("R1 reset opcode", {26'b0, opcode}, 32'h0);
    chk("R1 reset store data", mem_wdata, 32'h0);
    chk("R1 reset zero", {31'b0, zero}, 32'h1);

    run_lw(); run_lw();
    run_rt(); run_rt(); run_rt(); run_rt(); run_rt(); run_rt();
    run_sw(); run_sw();
    run_beq(); run_beq(); run_j();
    run_sw(); run_sw(); run_sw(); run_sw();

    @(negedge clk);
    chk("R9 load and R-type writeback (add)", mem[35], 32'hFFFF_FFF7);
    chk("R6 subtract", mem[37], 32'h0000_0017);
    chk("R6 signed set-less-than", mem[38], 32'h0000_0001);
    chk("R6 and", mem[39], 32'h0000_0000);
    chk("R6 or", mem[40], 32'hFFFF_FFF7);
    chk("R10 register 0 stays zero", mem[34], 32'h0000_0000);
    chk("R8 skipped words untouched", mem[36], 32'h1234_5678);

    step(16'h0000);
    chk("R7 PC after jump sequence", mem_addr, 32'h54);
    step(16'h0010);
    step(16'h2000);
    chk("R11 R5 held PC+4", mem_addr, 32'h58);
    step(16'h0020);
    step(16'h2030);
    chk("R5 sign-extended offset", mem_addr, 32'hF4);
    step(16'h2000);
    chk("R5 shifted offset", mem_addr, 32'h2D4);
    step(16'h0060);
    step(16'h2000);
    chk("R4 register A operand", mem_addr, 32'hA0);
    chk("R3 opcode held without enable", {26'b0, opcode}, 32'h2B);
    step(16'h8003);
    step(16'h0000);
    chk("R7 keep selection", mem_addr, 32'h54);

    for (int n = 0; n < 400; n++) step(16'($urandom));

    finish_run();
  end

endmodule